// File: doc/BRIEF.md
# SPI Card Block Write Transmitter

This block carries the data phase of a card write over a byte-level SPI master. A write command must already have been issued to the card. On `start_i` the block latches a block count, a block size and a single/multi mode flag, then for each block sends a lead byte and a start token. It takes the payload bytes from a ready/valid stream and sends them, followed by a 16-bit CRC trailer computed over the payload.

After each block the block polls the card for its data-response token and checks it. It then polls until the card stops signalling busy. In multi mode it closes the run with a stop token and waits for busy a second time. The block reports completion with a one-cycle `done_o` pulse. Two flags come with it: `err_crc_o` for a rejected or missing data response, and `err_tmo_o` for a busy wait that never ends. Each byte exchange is a request/acknowledge pair with the SPI master. The received byte arrives with the acknowledge.

Top module: `sd_blk_writer`

## Requirements
- R1: Every block opens with two bytes: 0xFF, then the start token 0xFE when `multi_i` was low at start or 0xFC when it was high.
- R2: Each block sends exactly `blk_size_i` payload bytes, in the order they arrive on the stream. `pay_ready_o` is raised only in the data phase, and only while no byte exchange is pending.
- R3: The payload is followed by its CRC16 (polynomial 0x1021, initial value 0, data fed most significant bit first). The high byte is sent first. The CRC restarts for each block.
- R4: After the CRC the block transmits 0xFF for each response poll, up to RESP_POLLS polls. The first received byte with bit 4 clear is the token. If its low 5 bits equal 0x05 the block is accepted. Any other token, or no token within RESP_POLLS polls, ends the run with `err_crc_o` high, and no further byte is exchanged.
- R5: Busy polls transmit 0xFF. Busy ends when 0xFF is received on any poll except the first; a 0xFF on the first poll is ignored. If BUSY_POLLS polls pass without this, the run ends with `err_tmo_o` high and no further byte is exchanged.
- R6: In multi mode, after the last block leaves busy, the block sends 0xFF, then 0xFD, and waits for busy under the R5 rule. In single mode the run ends right after the last block's busy wait.
- R7: `done_o` is high for exactly one cycle per run. `busy_o` is high from the cycle after start is accepted through the done cycle. The error flags are valid with `done_o` and are both low on success.
- R8: A block count of zero sends no block. In single mode the run completes at once with no byte exchanged. In multi mode only the stop sequence of R6 is sent.
- R9: While `spi_req_o` is high and not yet acknowledged, it stays high and `spi_tx_o` stays stable.
- R10: A start pulse while `busy_o` is high has no effect on the byte stream or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a write run (ignored while busy) |
| multi_i | input | 1 | Multi-block mode select, latched at start |
| blk_cnt_i | input | CNT_W | Number of blocks, latched at start |
| blk_size_i | input | SIZE_W | Payload bytes per block (at least 1), latched at start |
| pay_data_i | input | 8 | Payload stream byte |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_ready_o | output | 1 | Payload byte accepted this cycle when valid |
| spi_req_o | output | 1 | Byte exchange request to the SPI master |
| spi_tx_o | output | 8 | Byte to transmit |
| spi_ack_i | input | 1 | Exchange complete, one cycle per request |
| spi_rx_i | input | 8 | Byte received, valid with `spi_ack_i` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete, one cycle |
| err_crc_o | output | 1 | Data response rejected or missing |
| err_tmo_o | output | 1 | Busy wait exceeded its poll limit |

## Verification
The assertions take for granted that the SPI master answers each request with one acknowledge pulse, and only while a request is raised. They also assume `blk_size_i` is nonzero when a run starts. The bench's master model acknowledges only when it sees a raised request and no acknowledge pending, so it never acknowledges twice for one byte. Every run the bench starts has a block size from 1 to 4. The bench also drives the payload stream with and without gaps in `pay_valid_i`. Its start pulses during a run test R10 only, and the assertions do not rely on them.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_TOKEN,
    ST_FETCH,
    ST_SEND,
    ST_CRC_HI,
    ST_CRC_LO,
    ST_RESP,
    ST_BUSY,
    ST_STOP_LEAD,
    ST_STOP_TOK,
    ST_STOP_BUSY,
    ST_DONE
  } wr_state_e;

  localparam logic [7:0] BYTE_IDLE  = 8'hFF;
  localparam logic [7:0] TOK_SINGLE = 8'hFE;
  localparam logic [7:0] TOK_MULTI  = 8'hFC;
  localparam logic [7:0] TOK_STOP   = 8'hFD;
  localparam logic [4:0] RESP_OK    = 5'h05;

  function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  import sdw_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= '0;
    else if (clr_i)  crc_o <= '0;
    else if (en_i)   crc_o <= crc16_step(crc_o, data_i);
  end
endmodule

// File: rtl/sdw_poll_ctr.sv
module sdw_poll_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/sd_blk_writer.sv
module sd_blk_writer #(
  parameter int CNT_W      = 8,
  parameter int SIZE_W     = 10,
  parameter int RESP_POLLS = 8,
  parameter int BUSY_POLLS = 3000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              multi_i,
  input  logic [CNT_W-1:0]  blk_cnt_i,
  input  logic [SIZE_W-1:0] blk_size_i,
  input  logic [7:0]        pay_data_i,
  input  logic              pay_valid_i,
  output logic              pay_ready_o,
  output logic              spi_req_o,
  output logic [7:0]        spi_tx_o,
  input  logic              spi_ack_i,
  input  logic [7:0]        spi_rx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_crc_o,
  output logic              err_tmo_o
);
  import sdw_pkg::*;

  localparam int MAX_POLLS = (BUSY_POLLS > RESP_POLLS) ? BUSY_POLLS : RESP_POLLS;
  localparam int POLL_W    = $clog2(MAX_POLLS + 1);
  localparam logic [POLL_W-1:0] RESP_LAST = POLL_W'(RESP_POLLS - 1);
  localparam logic [POLL_W-1:0] BUSY_LAST = POLL_W'(BUSY_POLLS - 1);

  wr_state_e         state_q, state_d;
  logic              multi_q;
  logic [CNT_W-1:0]  cnt_q, blk_q;
  logic [SIZE_W-1:0] size_q, byte_q;
  logic [7:0]        data_q;
  logic              ecrc_q, etmo_q;

  logic              ack, take, busy_end, last_blk;
  logic              poll_clr, poll_inc, crc_clr, set_crc, set_tmo;
  logic [POLL_W-1:0] poll_cnt;
  logic [15:0]       crc;

  sdw_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (take),
    .data_i (pay_data_i),
    .crc_o  (crc)
  );

  sdw_poll_ctr #(.W(POLL_W)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .cnt_o  (poll_cnt)
  );

  always_comb begin
    unique case (state_q)
      ST_LEAD, ST_TOKEN, ST_SEND, ST_CRC_HI, ST_CRC_LO,
      ST_RESP, ST_BUSY, ST_STOP_LEAD, ST_STOP_TOK, ST_STOP_BUSY: spi_req_o = 1'b1;
      default: spi_req_o = 1'b0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_TOKEN:    spi_tx_o = multi_q ? TOK_MULTI : TOK_SINGLE;
      ST_SEND:     spi_tx_o = data_q;
      ST_CRC_HI:   spi_tx_o = crc[15:8];
      ST_CRC_LO:   spi_tx_o = crc[7:0];
      ST_STOP_TOK: spi_tx_o = TOK_STOP;
      default:     spi_tx_o = BYTE_IDLE;
    endcase
  end

  assign ack         = spi_ack_i & spi_req_o;
  assign pay_ready_o = (state_q == ST_FETCH);
  assign take        = pay_ready_o & pay_valid_i;
  // first busy poll never ends busy
  assign busy_end    = (poll_cnt != '0) && (spi_rx_i == BYTE_IDLE);
  assign last_blk    = (blk_q == cnt_q - CNT_W'(1));

  always_comb begin
    state_d  = state_q;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    crc_clr  = 1'b0;
    set_crc  = 1'b0;
    set_tmo  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        crc_clr = 1'b1;
        if (blk_cnt_i != '0) state_d = ST_LEAD;
        else                 state_d = multi_i ? ST_STOP_LEAD : ST_DONE;
      end
      ST_LEAD:  if (ack) state_d = ST_TOKEN;
      ST_TOKEN: if (ack) state_d = ST_FETCH;
      ST_FETCH: if (pay_valid_i) state_d = ST_SEND;
      ST_SEND:  if (ack) state_d = (byte_q == size_q - SIZE_W'(1)) ? ST_CRC_HI : ST_FETCH;
      ST_CRC_HI: if (ack) state_d = ST_CRC_LO;
      ST_CRC_LO: if (ack) begin
        state_d  = ST_RESP;
        poll_clr = 1'b1;
      end
      ST_RESP: if (ack) begin
        poll_inc = 1'b1;
        if (!spi_rx_i[4]) begin
          if (spi_rx_i[4:0] == RESP_OK) begin
            state_d  = ST_BUSY;
            poll_clr = 1'b1;
          end else begin
            state_d = ST_DONE;
            set_crc = 1'b1;
          end
        end else if (poll_cnt == RESP_LAST) begin
          state_d = ST_DONE;
          set_crc = 1'b1;
        end
      end
      ST_BUSY, ST_STOP_BUSY: if (ack) begin
        poll_inc = 1'b1;
        if (busy_end) begin
          if (state_q == ST_STOP_BUSY) state_d = ST_DONE;
          else if (!last_blk) begin
            state_d = ST_LEAD;
            crc_clr = 1'b1;
          end else state_d = multi_q ? ST_STOP_LEAD : ST_DONE;
        end else if (poll_cnt == BUSY_LAST) begin
          state_d = ST_DONE;
          set_tmo = 1'b1;
        end
      end
      ST_STOP_LEAD: if (ack) state_d = ST_STOP_TOK;
      ST_STOP_TOK: if (ack) begin
        state_d  = ST_STOP_BUSY;
        poll_clr = 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      multi_q <= 1'b0;
      cnt_q   <= '0;
      size_q  <= '0;
      blk_q   <= '0;
      byte_q  <= '0;
      data_q  <= '0;
      ecrc_q  <= 1'b0;
      etmo_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        multi_q <= multi_i;
        cnt_q   <= blk_cnt_i;
        size_q  <= blk_size_i;
        blk_q   <= '0;
        ecrc_q  <= 1'b0;
        etmo_q  <= 1'b0;
      end
      if (state_q == ST_LEAD) byte_q <= '0;
      if (take) data_q <= pay_data_i;
      if (state_q == ST_SEND && ack) byte_q <= byte_q + SIZE_W'(1);
      if (state_q == ST_BUSY && state_d == ST_LEAD) blk_q <= blk_q + CNT_W'(1);
      if (set_crc) ecrc_q <= 1'b1;
      if (set_tmo) etmo_q <= 1'b1;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign err_crc_o = ecrc_q;
  assign err_tmo_o = etmo_q;

endmodule

// File: rtl/sd_blk_writer_chk.sv
module sd_blk_writer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pay_ready_o,
  input logic       spi_req_o,
  input logic [7:0] spi_tx_o,
  input logic       spi_ack_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_crc_o,
  input logic       err_tmo_o
);
  assert_tx_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o)));

  assert_ready_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> !spi_req_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_err_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(err_crc_o && err_tmo_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!spi_req_o && !pay_ready_o));
endmodule

bind sd_blk_writer sd_blk_writer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pay_ready_o (pay_ready_o),
  .spi_req_o   (spi_req_o),
  .spi_tx_o    (spi_tx_o),
  .spi_ack_i   (spi_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_crc_o   (err_crc_o),
  .err_tmo_o   (err_tmo_o)
);

// File: tb/sd_blk_writer_tb.sv
module sd_blk_writer_tb;
  localparam int CNT_W = 8;
  localparam int SIZE_W = 10;
  localparam int RP = 8;
  localparam int BP = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic multi_i = 1'b0;
  logic [CNT_W-1:0] blk_cnt_i = '0;
  logic [SIZE_W-1:0] blk_size_i = '0;
  logic [7:0] pay_data_i;
  logic pay_valid_i;
  logic pay_ready_o, spi_req_o, spi_ack_i, busy_o, done_o, err_crc_o, err_tmo_o;
  logic [7:0] spi_tx_o, spi_rx_i;

  int checks = 0, fails = 0;
  int cyc = 0, pidx = 0, ridx = 0;
  bit gaps = 0;
  logic [7:0] rx_scr [1024];
  logic [7:0] got_tx [1024];
  logic [7:0] exp_tx [1024];
  int n_exp, rbase;

  always #5 clk_i = ~clk_i;

  sd_blk_writer #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .RESP_POLLS(RP), .BUSY_POLLS(BP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .multi_i(multi_i),
    .blk_cnt_i(blk_cnt_i), .blk_size_i(blk_size_i),
    .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
    .spi_req_o(spi_req_o), .spi_tx_o(spi_tx_o), .spi_ack_i(spi_ack_i), .spi_rx_i(spi_rx_i),
    .busy_o(busy_o), .done_o(done_o), .err_crc_o(err_crc_o), .err_tmo_o(err_tmo_o)
  );

  assign pay_data_i  = 8'((pidx * 29) + 7);
  assign pay_valid_i = !gaps || cyc[0];

  // SPI master model: one acknowledge per request, received byte from script
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spi_ack_i <= 1'b0;
      spi_rx_i  <= 8'hFF;
    end else begin
      cyc <= cyc + 1;
      if (pay_ready_o && pay_valid_i) pidx <= pidx + 1;
      spi_ack_i <= 1'b0;
      if (spi_req_o && !spi_ack_i) begin
        spi_ack_i <= 1'b1;
        spi_rx_i  <= rx_scr[ridx % 1024];
        got_tx[ridx % 1024] <= spi_tx_o;
        ridx <= ridx + 1;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic add(input logic [7:0] tx, input logic [7:0] rx);
    exp_tx[n_exp] = tx;
    rx_scr[(rbase + n_exp) % 1024] = rx;
    n_exp++;
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  // returns 1 on timeout
  task automatic busy_seq(input int bz, input bit ff1, output bit tmo);
    logic [7:0] rx;
    tmo = 1'b1;
    for (int i = 0; i < BP; i++) begin
      rx = (i == 0) ? (ff1 ? 8'hFF : 8'h00) : ((i == bz) ? 8'hFF : 8'h00);
      add(8'hFF, rx);
      if (i != 0 && rx == 8'hFF) begin
        tmo = 1'b0;
        break;
      end
    end
  endtask

  task automatic run(input bit m, input int cnt, input int size, input int rdel,
                     input logic [7:0] tok, input int bz, input bit ff1, input int sbz,
                     input bit gp, input bit poke, input string tag);
    int pbase, consumed, mism, first_bad;
    bit ec, et, tmo;
    logic [15:0] crc;
    logic [7:0] v;
    n_exp = 0; rbase = ridx; pbase = pidx; consumed = 0; ec = 0; et = 0;
    for (int b = 0; b < cnt && !ec && !et; b++) begin
      add(8'hFF, 8'hFF);
      add(m ? 8'hFC : 8'hFE, 8'hFF);
      crc = 16'h0000;
      for (int k = 0; k < size; k++) begin
        v = 8'(((pbase + consumed) * 29) + 7);
        crc = ref_crc(crc, v);
        add(v, 8'hFF);
        consumed++;
      end
      add(crc[15:8], 8'hFF);
      add(crc[7:0], 8'hFF);
      for (int j = 0; j < RP; j++) begin
        if (j < rdel) add(8'hFF, 8'hFF);
        else begin
          add(8'hFF, tok);
          break;
        end
      end
      if (rdel >= RP || tok[4:0] != 5'h05) begin
        ec = 1;
        break;
      end
      busy_seq(bz, ff1, tmo);
      if (tmo) et = 1;
    end
    if (m && !ec && !et) begin
      add(8'hFF, 8'hFF);
      add(8'hFD, 8'hFF);
      busy_seq(sbz, ff1, tmo);
      if (tmo) et = 1;
    end

    @(negedge clk_i);
    gaps = gp;
    multi_i = m;
    blk_cnt_i = CNT_W'(cnt);
    blk_size_i = SIZE_W'(size);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, {"R7 busy after start ", tag}, busy_o, 1);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      multi_i = !m;
      blk_cnt_i = 8'd7;
      blk_size_i = 10'd9;
      start_i = 1'b1;  // R10: must be ignored
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    check(err_crc_o == ec, {"R4 crc flag ", tag}, err_crc_o, ec);
    check(err_tmo_o == et, {"R5 timeout flag ", tag}, err_tmo_o, et);
    check(ridx - rbase == n_exp, {"R6 R8 R10 byte count ", tag}, ridx - rbase, n_exp);
    mism = 0; first_bad = 0;
    for (int k = 0; k < n_exp; k++)
      if (got_tx[(rbase + k) % 1024] !== exp_tx[k]) begin
        if (mism == 0) first_bad = k;
        mism++;
      end
    check(mism == 0, {"R1 R3 tx stream ", tag},
          (mism == 0) ? 0 : int'(got_tx[(rbase + first_bad) % 1024]),
          (mism == 0) ? 0 : int'(exp_tx[first_bad]));
    check(pidx - pbase == consumed, {"R2 payload taken ", tag}, pidx - pbase, consumed);
    @(negedge clk_i);
    check(!done_o && !busy_o, {"R7 done single cycle ", tag}, {done_o, busy_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !spi_req_o && !pay_ready_o, "R7 reset state",
          {busy_o, done_o, spi_req_o, pay_ready_o}, 0);
    check(!err_crc_o && !err_tmo_o, "R7 reset flags", {err_crc_o, err_tmo_o}, 0);

    // sweep: both modes, counts 0..3 (R8 at zero), sizes 1..4
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int s = 1; s < 5; s++)
          run(m[0], c, s, (c + s + m) % RP, (s == 2) ? 8'hE5 : 8'h05,
              1 + (c % 3), s[0], 1 + (s % 3), c[0] ^ s[0], (c == 2 && s == 3), "sweep");

    // R4: rejected tokens and missing token
    run(1'b1, 3, 2, 1, 8'h0B, 1, 0, 1, 0, 0, "R4 crc token");
    run(1'b0, 2, 3, 0, 8'h0D, 1, 0, 1, 0, 0, "R4 write error token");
    run(1'b1, 2, 1, RP, 8'h05, 1, 0, 1, 0, 0, "R4 no token");
    run(1'b0, 1, 2, RP - 1, 8'h05, 1, 0, 1, 0, 0, "R4 token on last poll");
    // R5: first-poll 0xFF ignored, busy timeout, late end
    run(1'b0, 1, 1, 0, 8'h05, 1, 1, 1, 0, 0, "R5 first poll ff");
    run(1'b1, 3, 2, 0, 8'h05, BP, 0, 1, 0, 0, "R5 block busy timeout");
    run(1'b0, 1, 2, 0, 8'h05, BP - 1, 1, 1, 0, 0, "R5 busy ends on last poll");
    // R6: stop busy timeout
    run(1'b1, 2, 2, 0, 8'h05, 2, 0, BP, 1, 0, "R6 stop busy timeout");
    // R10: start during multi run
    run(1'b1, 2, 4, 2, 8'h05, 2, 0, 2, 1, 1, "R10 start while busy");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule